// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when the analog-to-digital converter begins a group of conversions. Three sources can request a start. The first is an external pin. The second is an on-chip timer event. The third is a software write. The pin and the timer event each pass through a two-flop synchroniser and a low-width filter. Each has its own enable bit.

A qualified request sets a start flag. On the clock where the flag goes from clear to set, the block sends a one-clock start pulse to the conversion sequencer.

While the flag is set, any further request is ignored. In single mode, the sequencer's end-of-group strobe clears the flag, so the next trigger can start a new group. In continuous mode the flag stays set: only the first trigger acts until software writes zero to the flag.

The block also holds the converter's power-enable bit. This bit is clear at reset and clears itself while the chip is halted. Triggers act on the start flag whatever the state of this bit.

Top module: `conv_start_ctrl`

## Requirements
- R1: After reset, `start_flag`, `start_pulse` and `pwr_en` are all 0.
- R2: An enabled pin trigger (`ext_trig_n`) that is sampled low on two consecutive rising edges sets `start_flag`. The flag is set on the third rising edge after the second low sample.
- R3: A trigger input sampled low on only one edge, between high samples, has no effect. Each unbroken low run produces at most one start request.
- R4: While `ext_en` is 0, the pin source cannot set the flag. While `tmr_en` is 0, the timer source cannot set the flag.
- R5: An enabled timer event (`tmr_trig_n`) follows the same qualification and timing as the pin source.
- R6: A software write (`sw_wr`=1 with `sw_wdata`=1) sets the flag on the next rising edge, when the flag is clear.
- R7: Any start request that arrives while `start_flag` is 1 is ignored. It produces no pulse.
- R8: In single mode (`mode_cont`=0), `group_done`=1 while the flag is set clears the flag on the next edge.
- R9: In continuous mode (`mode_cont`=1), `group_done` leaves the flag set. Triggers after the first have no effect.
- R10: A software write of 0 (`sw_wr`=1, `sw_wdata`=0) clears the flag on the next edge, in either mode. Later triggers are accepted again. This write takes priority over every set source.
- R11: A trigger sets the flag even when `pwr_en` is 0.
- R12: `pwr_en` takes `pwr_wdata` on an edge where `pwr_wr`=1. `halt`=1 forces it to 0 on the next edge, and `halt` wins over a simultaneous write.
- R13: `start_pulse` is 1 for exactly the one cycle in which `start_flag` has just changed from 0 to 1. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig_n | input | 1 | External trigger pin, active low, asynchronous |
| tmr_trig_n | input | 1 | On-chip timer trigger event, active low |
| ext_en | input | 1 | Enable for the pin source |
| tmr_en | input | 1 | Enable for the timer source |
| sw_wr | input | 1 | Software write strobe to the start flag |
| sw_wdata | input | 1 | Value written to the start flag |
| mode_cont | input | 1 | 1 = continuous mode, 0 = single mode |
| group_done | input | 1 | End-of-group strobe from the sequencer |
| pwr_wr | input | 1 | Write strobe for the power-enable bit |
| pwr_wdata | input | 1 | Value written to the power-enable bit |
| halt | input | 1 | Chip halt indication |
| start_flag | output | 1 | Start/busy flag |
| start_pulse | output | 1 | One-clock start pulse to the sequencer |
| pwr_en | output | 1 | Converter power enable |

## Verification
Software writes, `group_done` and power writes take effect on the first rising edge after they are driven. A pin or timer trigger takes effect on the third edge after its second low sample: two edges for synchronisation, one for the filter and event register, then the flag register.

The bench keeps a per-source record of low runs and a three-deep delay line. This places each expected request on exactly that edge. The bench drives every input at the falling edge and compares all outputs at the next falling edge, half a period after the edge that updated them.

// File: rtl/conv_start_pkg.sv
package conv_start_pkg;

    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int NUM_SRC = 2;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_CONT   = 1'b1
    } conv_mode_e;

    typedef struct packed {
        logic flag;
        logic pulse;
    } start_state_t;

endpackage

// File: rtl/trig_filter.sv
module trig_filter #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic evt
);

    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LOW);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_LOW - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          filt;
        logic          evt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = trig_n;
        st_d.s2 = st_q.s1;
        if (st_q.s2) begin
            st_d.cnt  = '0;
            st_d.filt = 1'b1;
        end else begin
            if (st_q.cnt < CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt >= CNT_LAST) begin
                st_d.filt = 1'b0;
            end
        end
        st_d.evt = st_q.filt & ~st_d.filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, cnt: '0, filt: 1'b1, evt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt = st_q.evt;

    // R3: the filtered level only falls after a low synchronised sample
    a_r3_fall_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.filt) |-> !$past(st_q.s2));

    // R3: one request per unbroken low run
    a_r3_single_evt: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt);

    // R2: an event coincides with a low filtered level
    a_r2_evt_filt_low: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> !st_q.filt);

endmodule

// File: rtl/start_flag_core.sv
module start_flag_core
    import conv_start_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic [N_SRC-1:0] src_en,
    input  logic             sw_wr,
    input  logic             sw_wdata,
    input  conv_mode_e       mode,
    input  logic             group_done,
    output logic             flag,
    output logic             pulse
);

    start_state_t st_d, st_q;
    logic         hw_req;
    logic         sw_set;
    logic         sw_clr;
    logic         grp_clr;

    always_comb begin
        hw_req  = |(src_evt & src_en);
        sw_set  = sw_wr & sw_wdata;
        sw_clr  = sw_wr & ~sw_wdata;
        grp_clr = st_q.flag & group_done & (mode == MODE_SINGLE);

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (sw_clr) begin
            st_d.flag = 1'b0;
        end else if (grp_clr) begin
            st_d.flag = 1'b0;
        end else if (!st_q.flag && (hw_req || sw_set)) begin
            st_d.flag  = 1'b1;
            st_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign pulse = st_q.pulse;

    // R13: the pulse marks only a fresh rise of the flag
    a_r13_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> (st_q.flag && !$past(st_q.flag)));

    // R13: every rise of the flag carries a pulse
    a_r13_rise_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> st_q.pulse);

    // R7: no new start while already set
    a_r7_no_pulse_when_set: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |=> !st_q.pulse);

    // R8: single mode clears at end of group
    a_r8_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && group_done && mode == MODE_SINGLE) |=> !st_q.flag);

    // R9: continuous mode holds the flag
    a_r9_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && mode == MODE_CONT && !(sw_wr && !sw_wdata)) |=> st_q.flag);

    // R10: software zero write clears
    a_r10_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !sw_wdata) |=> !st_q.flag);

endmodule

// File: rtl/power_ctrl.sv
module power_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_wr,
    input  logic pwr_wdata,
    input  logic halt,
    output logic pwr_en
);

    logic pwr_d, pwr_q;

    always_comb begin
        pwr_d = pwr_q;
        if (halt) begin
            pwr_d = 1'b0;
        end else if (pwr_wr) begin
            pwr_d = pwr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q <= 1'b0;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign pwr_en = pwr_q;

    // R12: halt powers the converter down
    a_r12_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !pwr_q);

    // R12: bit changes only through a write or halt
    a_r12_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !pwr_wr) |=> $stable(pwr_q));

endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl
    import conv_start_pkg::*;
#(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_trig_n,
    input  logic tmr_trig_n,
    input  logic ext_en,
    input  logic tmr_en,
    input  logic sw_wr,
    input  logic sw_wdata,
    input  logic mode_cont,
    input  logic group_done,
    input  logic pwr_wr,
    input  logic pwr_wdata,
    input  logic halt,
    output logic start_flag,
    output logic start_pulse,
    output logic pwr_en
);

    logic [NUM_SRC-1:0] trig_n_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] evt_vec;
    conv_mode_e         mode;

    always_comb begin
        trig_n_vec          = '1;
        trig_n_vec[SRC_EXT] = ext_trig_n;
        trig_n_vec[SRC_TMR] = tmr_trig_n;
        en_vec              = '0;
        en_vec[SRC_EXT]     = ext_en;
        en_vec[SRC_TMR]     = tmr_en;
        mode                = mode_cont ? MODE_CONT : MODE_SINGLE;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        trig_filter #(.MIN_LOW(MIN_LOW)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig_n (trig_n_vec[g]),
            .evt    (evt_vec[g])
        );
    end

    start_flag_core #(.N_SRC(NUM_SRC)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (evt_vec),
        .src_en     (en_vec),
        .sw_wr      (sw_wr),
        .sw_wdata   (sw_wdata),
        .mode       (mode),
        .group_done (group_done),
        .flag       (start_flag),
        .pulse      (start_pulse)
    );

    power_ctrl u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_wr    (pwr_wr),
        .pwr_wdata (pwr_wdata),
        .halt      (halt),
        .pwr_en    (pwr_en)
    );

    // R11: power state never blocks a start request from setting the flag
    a_r11_start_without_power: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_flag && (evt_vec & en_vec) != '0 && !sw_wr) |=> start_flag);

endmodule

// File: tb/tb_conv_start_ctrl.sv
module tb_conv_start_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW    = 2;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_trig_n = 1'b1, tmr_trig_n = 1'b1;
    logic ext_en = 1'b1, tmr_en = 1'b1;
    logic sw_wr = 1'b0, sw_wdata = 1'b0;
    logic mode_cont = 1'b0, group_done = 1'b0;
    logic pwr_wr = 1'b0, pwr_wdata = 1'b0, halt = 1'b0;
    logic start_flag, start_pulse, pwr_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int m_run [2];
    bit m_dly [2][3];
    bit m_flag, m_pulse, m_pwr;
    int pulses_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_start_ctrl #(.MIN_LOW(MIN_LOW)) dut (
        .clk(clk), .rst_n(rst_n), .ext_trig_n(ext_trig_n), .tmr_trig_n(tmr_trig_n),
        .ext_en(ext_en), .tmr_en(tmr_en), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .mode_cont(mode_cont), .group_done(group_done), .pwr_wr(pwr_wr),
        .pwr_wdata(pwr_wdata), .halt(halt), .start_flag(start_flag),
        .start_pulse(start_pulse), .pwr_en(pwr_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // next power bit from R12
    function automatic bit next_pwr(bit cur, bit h, bit wr, bit wd);
        if (h) return 1'b0;
        if (wr) return wd;
        return cur;
    endfunction

    // next flag from R6..R10
    function automatic bit next_flag(bit cur, bit req, bit swc, bit gd, bit cont);
        if (swc) return 1'b0;
        if (cur && gd && !cont) return 1'b0;
        if (!cur && req) return 1'b1;
        return cur;
    endfunction

    task automatic model_edge();
        bit cons [2];
        bit lvl [2];
        bit req;
        lvl[0] = ext_trig_n;
        lvl[1] = tmr_trig_n;
        for (int s = 0; s < 2; s++) begin
            bit hit;
            if (lvl[s]) m_run[s] = 0;
            else if (m_run[s] <= MIN_LOW) m_run[s]++;
            hit = !lvl[s] && (m_run[s] == MIN_LOW);
            cons[s]     = m_dly[s][2];
            m_dly[s][2] = m_dly[s][1];
            m_dly[s][1] = m_dly[s][0];
            m_dly[s][0] = hit;
        end
        req = (sw_wr && sw_wdata) || (cons[0] && ext_en) || (cons[1] && tmr_en);
        m_pulse = !m_flag && req && !(sw_wr && !sw_wdata);
        m_flag  = next_flag(m_flag, req, sw_wr && !sw_wdata, group_done, mode_cont);
        m_pwr   = next_pwr(m_pwr, halt, pwr_wr, pwr_wdata);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " start_flag"}, start_flag, m_flag);
        chk({tag, " start_pulse (R13)"}, start_pulse, m_pulse);
        chk({tag, " pwr_en (R12)"}, pwr_en, m_pwr);
        if (start_pulse) pulses_seen++;
    endtask

    task automatic clr_strobes();
        sw_wr = 1'b0; group_done = 1'b0; pwr_wr = 1'b0; halt = 1'b0;
    endtask

    task automatic low_run(input bit ext, input int n, input string tag);
        if (ext) ext_trig_n = 1'b0; else tmr_trig_n = 1'b0;
        for (int i = 0; i < n; i++) step(tag);
        ext_trig_n = 1'b1; tmr_trig_n = 1'b1;
        for (int i = 0; i < 5; i++) step(tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_run = '{0, 0};
        m_dly = '{'{0, 0, 0}, '{0, 0, 0}};
        m_flag = 0; m_pulse = 0; m_pwr = 0;
        pulses_seen = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 start_flag", start_flag, 1'b0);
        chk("R1 start_pulse", start_pulse, 1'b0);
        chk("R1 pwr_en", pwr_en, 1'b0);
        rst_n = 1'b1;
        step("R1");

        // R2 / R11: pin trigger with power off
        pulses_seen = 0;
        ext_trig_n = 1'b0;
        step("R2"); step("R2");
        ext_trig_n = 1'b1;
        step("R2"); step("R2");
        chk("R2 flag not yet set", start_flag, 1'b0);
        step("R2");
        chk("R11 flag set with pwr_en=0", start_flag, 1'b1);
        chk("R13 pulse on rise", start_pulse, 1'b1);
        step("R13");
        chk("R13 pulse one clock", start_pulse, 1'b0);

        // R7: trigger while busy ignored
        pulses_seen = 0;
        low_run(1'b0, 4, "R7");
        chk("R7 no pulse while set", pulses_seen[0], 1'b0);

        // R8: single mode end of group
        group_done = 1'b1; step("R8"); clr_strobes();
        chk("R8 flag cleared", start_flag, 1'b0);

        // R3: one-sample glitch rejected
        low_run(1'b1, 1, "R3");
        chk("R3 glitch ignored", start_flag, 1'b0);

        // R4: disabled pin source
        ext_en = 1'b0;
        low_run(1'b1, 6, "R4");
        chk("R4 disabled source ignored", start_flag, 1'b0);
        ext_en = 1'b1;

        // R5: timer source
        low_run(1'b0, 3, "R5");
        chk("R5 timer sets flag", start_flag, 1'b1);
        group_done = 1'b1; step("R5"); clr_strobes();

        // R9 / R6: continuous mode with software start
        mode_cont = 1'b1;
        sw_wr = 1'b1; sw_wdata = 1'b1; step("R6"); clr_strobes();
        chk("R6 software start", start_flag, 1'b1);
        group_done = 1'b1; step("R9"); clr_strobes();
        pulses_seen = 0;
        low_run(1'b1, 3, "R9");
        chk("R9 flag held", start_flag, 1'b1);
        chk("R9 later trigger ignored", pulses_seen[0], 1'b0);

        // R10: software clear re-arms
        sw_wr = 1'b1; sw_wdata = 1'b0; step("R10"); clr_strobes();
        chk("R10 cleared", start_flag, 1'b0);
        low_run(1'b1, 2, "R10");
        chk("R10 re-armed", start_flag, 1'b1);
        sw_wr = 1'b1; sw_wdata = 1'b0; step("R10"); clr_strobes();
        mode_cont = 1'b0;

        // R12: power bit
        pwr_wr = 1'b1; pwr_wdata = 1'b1; step("R12"); clr_strobes();
        chk("R12 power on", pwr_en, 1'b1);
        pwr_wr = 1'b1; pwr_wdata = 1'b1; halt = 1'b1; step("R12"); clr_strobes();
        chk("R12 halt wins", pwr_en, 1'b0);

        // random phase
        void'($urandom(32'd2024));
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(3) == 0) ext_trig_n = ~ext_trig_n;
            if ($urandom_range(4) == 0) tmr_trig_n = ~tmr_trig_n;
            if ($urandom_range(40) == 0) ext_en = ~ext_en;
            if ($urandom_range(40) == 0) tmr_en = ~tmr_en;
            if ($urandom_range(60) == 0) mode_cont = ~mode_cont;
            sw_wr      = ($urandom_range(15) == 0);
            sw_wdata   = $urandom_range(1);
            group_done = ($urandom_range(7) == 0);
            pwr_wr     = ($urandom_range(15) == 0);
            pwr_wdata  = $urandom_range(1);
            halt       = ($urandom_range(31) == 0);
            step("R2/R8/R9 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule